// File: doc/BRIEF.md
# Alarm Status and Interrupt Register Bank

This block collects alarm indications from the line monitors and presents them to a host through a small synchronous register port. There are two kinds of source. Level sources are line-signal alarm, driver-open fault, pattern lock and self-test pass. Event sources are one-cycle pulses for elastic-store overflow and underflow.

For each level source the bank keeps a transition bit. That bit latches any change of the level. Each event source has a sticky bit that holds the event until the host reads it. A host-written mask register does two jobs. Writing 1 to a bit clears that source's pending bit and masks it. Writing 0 unmasks it. Any pending bit that is not masked pulls the active-low interrupt output low.

The host port has no flow control. Every strobe is taken in the cycle it is presented. Read data is registered and appears on the cycle after the read strobe. The data is held until the next read. There is no valid/ready edge because there is no data stream.

Top module: `alarm_irq_bank`

## Requirements
- R1: A read of address 0 returns the live levels on `rdata[3:0]` (bit0 line alarm, bit1 driver open, bit2 pattern lock, bit3 self-test pass) with upper bits 0. Read data appears one cycle after the read strobe and is held until the next read.
- R2: A change of any level bit between consecutive cycles sets the matching transition bit, read at address 1 on `rdata[3:0]`. Reading it does not clear it.
- R3: A pending transition or sticky bit that is not masked drives `irq_n` low in the cycle after it is set.
- R4: Writing address 3 with a 1 in a bit clears that source's pending bit and masks it. Bits 0..3 are the level sources, bit4 is overflow and bit5 is underflow. A level change in the same cycle as the clear wins, and the bit stays set.
- R5: Writing 0 to a mask bit unmasks that source. A bit still pending then drives `irq_n` low again. Address 3 reads back the mask.
- R6: An overflow pulse (`evt_i[0]`) or underflow pulse (`evt_i[1]`) sets a sticky bit, read at address 2 on `rdata[1:0]`. A read of address 2 returns the bits and clears them at the same edge.
- R7: An event pulse arriving in the same cycle as the read of address 2 keeps its sticky bit set. The read data shows the value before the event.
- R8: `irq_n` is the inverse of the OR over all unmasked pending bits. When nothing is pending and unmasked, it is high.
- R9: Reset (active-low `rst_n`) clears all pending bits, the mask and read data. The level history is 0, so `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_i | input | 4 | Live alarm levels |
| evt_i | input | 2 | Overflow/underflow event pulses |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (address 3 only) |
| addr | input | 2 | Register select |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases are two collisions at one clock edge: a read-clear meeting a new event, and a write-one clear meeting a fresh level change. Each depends on two ports changing in exactly the same cycle. The stimulus table places the event pulse in the same row as the sticky read, and the level change in the same row as the mask write. The following rows read the register back to show the bit survived. A masked-then-unmasked sequence also shows that a pending bit hidden by the mask drives the interrupt again.

// File: rtl/alarm_bank_pkg.sv
package alarm_bank_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_TRANS  = 2'd1,
    REG_STICKY = 2'd2,
    REG_MASK   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/alarm_change_latch.sv
module alarm_change_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] trans_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    trans_o[b] <= 1'b0;
      else if (lvl_i[b] != prev_q[b]) trans_o[b] <= 1'b1;
      else if (clr_i[b])              trans_o[b] <= 1'b0;
    end

    AST_CHANGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i[b] != prev_q[b]) |=> trans_o[b]); // R2
  end
endmodule

// File: rtl/alarm_sticky_bits.sv
module alarm_sticky_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         rd_clr_i,
  input  logic [N-1:0] wr_clr_i,
  output logic [N-1:0] sticky_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sticky_o[b] <= 1'b0;
      else if (evt_i[b])                   sticky_o[b] <= 1'b1;
      else if (rd_clr_i || wr_clr_i[b])    sticky_o[b] <= 1'b0;
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[b] |=> sticky_o[b]); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && !evt_i[b]) |=> !sticky_o[b]); // R6
  end
endmodule

// File: rtl/alarm_host_regs.sv
module alarm_host_regs
  import alarm_bank_pkg::*;
#(
  parameter int N_LVL = 4,
  parameter int N_EVT = 2,
  localparam int W = N_LVL + N_EVT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [W-1:0]     wdata,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic [N_LVL-1:0] trans_i,
  input  logic [N_EVT-1:0] sticky_i,
  output logic [W-1:0]     mask_o,
  output logic [W-1:0]     wclr_o,
  output logic             rdclr_o,
  output logic [W-1:0]     rdata
);
  logic mask_wr;
  logic [W-1:0] rd_mux;

  assign mask_wr = wr_en && (addr == REG_MASK);
  assign wclr_o  = mask_wr ? wdata : '0;
  assign rdclr_o = rd_en && (addr == REG_STICKY);

  always_comb begin
    unique case (reg_sel_e'(addr))
      REG_STATUS: rd_mux = {{N_EVT{1'b0}}, lvl_i};
      REG_TRANS:  rd_mux = {{N_EVT{1'b0}}, trans_i};
      REG_STICKY: rd_mux = {{N_LVL{1'b0}}, sticky_i};
      default:    rd_mux = mask_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      rdata  <= '0;
    end else begin
      if (mask_wr) mask_o <= wdata;
      if (rd_en)   rdata  <= rd_mux;
    end
  end

  AST_MASK_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_o == $past(wdata))); // R4
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R1
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank #(
  parameter int N_LVL = 4,
  parameter int N_EVT = 2,
  localparam int W = N_LVL + N_EVT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             irq_n
);
  logic [N_LVL-1:0] trans;
  logic [N_EVT-1:0] sticky;
  logic [W-1:0]     mask, wclr, pending;
  logic             rdclr;

  alarm_host_regs #(.N_LVL(N_LVL), .N_EVT(N_EVT)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .lvl_i(lvl_i), .trans_i(trans), .sticky_i(sticky),
    .mask_o(mask), .wclr_o(wclr), .rdclr_o(rdclr), .rdata(rdata)
  );

  alarm_change_latch #(.N(N_LVL)) u_chg (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .clr_i(wclr[N_LVL-1:0]),
    .trans_o(trans)
  );

  alarm_sticky_bits #(.N(N_EVT)) u_stk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_clr_i(rdclr),
    .wr_clr_i(wclr[W-1:N_LVL]), .sticky_o(sticky)
  );

  assign pending = {sticky, trans};
  assign irq_n   = ~|(pending & ~mask);

  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ~mask[W-1:N_LVL]) && !(wr_en && addr == 2'd3)) |=> !irq_n); // R3
endmodule

// File: tb/test_alarm_irq_bank.sv
module test_alarm_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;
  // {lvl[4], evt[2], rd, wr, addr[2], wdata[6], exp_irq_n, exp_rdata[6]}
  localparam logic [22:0] VEC [NV] = '{
    {4'h0,2'b00,1'b0,1'b0,2'd0,6'd0 ,1'b1,6'd0 }, // 0 idle R8
    {4'h1,2'b00,1'b0,1'b0,2'd0,6'd0 ,1'b0,6'd0 }, // 1 ais rises R2 R3
    {4'h1,2'b00,1'b1,1'b0,2'd1,6'd0 ,1'b0,6'd1 }, // 2 read trans R2
    {4'h1,2'b00,1'b1,1'b0,2'd0,6'd0 ,1'b0,6'd1 }, // 3 read status R1
    {4'h1,2'b00,1'b0,1'b1,2'd3,6'd1 ,1'b1,6'd1 }, // 4 clear+mask R4
    {4'h0,2'b00,1'b0,1'b0,2'd0,6'd0 ,1'b1,6'd1 }, // 5 masked change R4
    {4'h0,2'b00,1'b1,1'b0,2'd1,6'd0 ,1'b1,6'd1 }, // 6 trans still latched R2
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd0 ,1'b0,6'd1 }, // 7 unmask R5
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd1 ,1'b1,6'd1 }, // 8
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd0 ,1'b1,6'd1 }, // 9 unmask none pending R5
    {4'h4,2'b00,1'b0,1'b0,2'd0,6'd0 ,1'b0,6'd1 }, // 10 lock rises R3
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd4 ,1'b1,6'd1 }, // 11 change vs clear R4
    {4'h0,2'b00,1'b1,1'b0,2'd1,6'd0 ,1'b1,6'd4 }, // 12 survived R4
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd0 ,1'b0,6'd4 }, // 13 R5
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd4 ,1'b1,6'd4 }, // 14
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd0 ,1'b1,6'd4 }, // 15
    {4'h0,2'b01,1'b0,1'b0,2'd0,6'd0 ,1'b0,6'd4 }, // 16 overflow R6
    {4'h0,2'b00,1'b1,1'b0,2'd2,6'd0 ,1'b1,6'd1 }, // 17 read clears R6
    {4'h0,2'b00,1'b1,1'b0,2'd2,6'd0 ,1'b1,6'd0 }, // 18 R6
    {4'h0,2'b10,1'b1,1'b0,2'd2,6'd0 ,1'b0,6'd0 }, // 19 event vs read R7
    {4'h0,2'b00,1'b1,1'b0,2'd2,6'd0 ,1'b1,6'd2 }, // 20 R7
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd16,1'b1,6'd2 }, // 21 mask ovf
    {4'h0,2'b01,1'b0,1'b0,2'd0,6'd0 ,1'b1,6'd2 }, // 22 masked event R4
    {4'h0,2'b00,1'b1,1'b0,2'd2,6'd0 ,1'b1,6'd1 }, // 23 R6
    {4'h0,2'b00,1'b0,1'b1,2'd3,6'd0 ,1'b1,6'd1 }, // 24 R5
    {4'h8,2'b00,1'b0,1'b0,2'd0,6'd0 ,1'b0,6'd1 }, // 25 bist pass R3
    {4'h8,2'b00,1'b1,1'b0,2'd0,6'd0 ,1'b0,6'd8 }, // 26 R1
    {4'h8,2'b00,1'b1,1'b0,2'd3,6'd0 ,1'b0,6'd0 }, // 27 mask read R5
    {4'h8,2'b00,1'b0,1'b1,2'd3,6'd63,1'b1,6'd0 }, // 28 mask all R4
    {4'h8,2'b00,1'b1,1'b0,2'd3,6'd0 ,1'b1,6'd63}, // 29 R5
    {4'h2,2'b11,1'b0,1'b0,2'd0,6'd0 ,1'b1,6'd63}, // 30 all masked R8
    {4'h2,2'b00,1'b1,1'b0,2'd1,6'd0 ,1'b1,6'd10}, // 31 R2
    {4'h2,2'b00,1'b0,1'b1,2'd3,6'd0 ,1'b0,6'd10}  // 32 R5 R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] lvl_i = '0;
  logic [1:0] evt_i = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [5:0] wdata = '0, rdata;
  logic irq_n;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_bank i_alarm_irq_bank (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .evt_i(evt_i), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    lvl_i = '0; evt_i = '0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset irq_n", {5'd0, irq_n}, 6'd1);
    check("R9 reset rdata", rdata, 6'd0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {lvl_i, evt_i, rd_en, wr_en, addr, wdata} = VEC[v][22:7];
      @(posedge clk);
      #(CLK_PERIOD/4);
      check($sformatf("R3/R8 vec %0d irq_n", v), {5'd0, irq_n}, {5'd0, VEC[v][6]});
      check($sformatf("R1 vec %0d rdata", v), rdata, VEC[v][5:0]);
    end
    // Directed: reset with pending sources clears everything (R9)
    @(negedge clk);
    idle();
    check("R9 pending before reset", {5'd0, irq_n}, 6'd0);
    rst_n = 1'b0;
    #1;
    check("R9 irq_n after reset", {5'd0, irq_n}, 6'd1);
    check("R9 rdata after reset", rdata, 6'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); rd_en = 1'b1; addr = 2'd3;
    @(negedge clk); rd_en = 1'b0;
    check("R9 mask cleared by reset", rdata, 6'd0);
    // Directed: underflow and overflow together, one read clears both (R6)
    evt_i = 2'b11;
    @(negedge clk); evt_i = 2'b00;
    check("R6 both sticky raise irq", {5'd0, irq_n}, 6'd0);
    rd_en = 1'b1; addr = 2'd2;
    @(negedge clk); rd_en = 1'b0;
    check("R6 both sticky read", rdata, 6'd3);
    check("R6 read cleared irq", {5'd0, irq_n}, 6'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule